// File: doc/BRIEF.md
# Decode-Stage Operand Interlock

This unit sits beside the decode stage of an in-order pipeline with separate integer and floating-point register files. Every cycle it looks at the instruction waiting in decode: its class, its two source register indices, its destination index and a valid bit. It raises `stall` whenever one of the sources names a result that cannot yet reach that instruction through the bypass network. While `stall` is high, decode holds its instruction and fetch is frozen.

Each architectural register in each file owns a small down-counter. It is loaded with the producer's base latency in the cycle the producer leaves decode, and it counts down once per clock until it reaches zero. The gap a consumer needs is the producer latency minus a credit that depends on the consumer. Only the data operand of a floating-point store earns a credit, because it is needed one stage later than an arithmetic operand. For this reason one pending result can hold a floating-point add but let a store of the same register go through. Gaps are counted in cycles, so idle decode slots count as intervening instructions.

Class codes on `instClass`: 0 integer ALU, 1 integer load, 2 integer store, 3 conditional branch, 4 FP arithmetic, 5 FP load, 6 FP store, 7 no operation.

Top module: `decodeInterlock`

## Requirements
- R1: A synchronous reset clears every countdown and holds `stall` low. A result issued before the reset never stalls an instruction decoded after it.
- R2: An FP arithmetic result (class 4) read by FP arithmetic (class 4) on either operand needs three intervening cycles. With k intervening cycles, where k < 3, the consumer stalls for exactly 3 - k cycles.
- R3: An FP arithmetic result read as FP store data (class 6, source B) needs two intervening cycles, so the consumer stalls for 2 - k cycles.
- R4: An FP load result (class 5) read by FP arithmetic needs one intervening cycle. An adjacent consumer stalls for one cycle.
- R5: An FP load result read as FP store data never stalls.
- R6: An integer load result (class 1) needs one intervening cycle before any integer consumer: ALU operands, branch operands, or store data (class 2, source B).
- R7: An integer ALU result (class 0) never stalls any consumer, branches (class 3) included.
- R8: Integer register index 0 never creates a dependence, even when it is the destination of an integer load.
- R9: `stall` is low whenever `instValid` is low. Source B is checked as well as source A.
- R10: The base-address operand of any load or store (source A, integer file) gets no credit. It stalls one cycle on an integer load issued in the previous cycle, for FP loads and FP stores as well.
- R11: A stalled instruction loads no countdown. Its own latency counts from the cycle in which it finally leaves decode. This also holds when it writes its own source register.
- R12: `stall` never stays high for more than the largest producer latency (3) consecutive cycles.
- R13: The two register files are tracked separately. A pending FP result in register n does not stall an integer read of register n, and a pending integer result does not stall an FP read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Decode holds a real instruction |
| instClass | input | 3 | Instruction class code (see above) |
| srcAIdx | input | 5 | Source A index (base address for memory classes) |
| srcBIdx | input | 5 | Source B index (store data for store classes) |
| dstIdx | input | 5 | Destination register index |
| stall | output | 1 | Hold decode and freeze fetch |

## Verification
The two functions that can fall in the same cycle are stall generation and the update of the tracking state. The sharpest case is an instruction that is itself stalled and also writes a register, most pointedly the register it is waiting on. The bench provokes this with an FP arithmetic instruction that reads and writes the same register right behind a producer of that register. It then follows with an adjacent reader. It judges the result by requiring exactly three stall cycles for each of the two. If a stalled instruction reloaded its own countdown, the stall would never end.

// File: rtl/ilkPkg.sv
package ilkPkg;

  typedef enum logic [2:0] {
    CLS_INT_ALU   = 3'd0,
    CLS_INT_LOAD  = 3'd1,
    CLS_INT_STORE = 3'd2,
    CLS_BRANCH    = 3'd3,
    CLS_FP_ALU    = 3'd4,
    CLS_FP_LOAD   = 3'd5,
    CLS_FP_STORE  = 3'd6,
    CLS_NOP       = 3'd7
  } instClass_e;

  // strobes from control to the countdown files
  typedef struct packed {
    logic loadInt;
    logic loadFp;
  } trackStrobe_t;

endpackage

// File: rtl/ilkCountFile.sv
module ilkCountFile #(
  parameter int REGS  = 32,
  parameter int IDX_W = 5,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] loadIdx,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [IDX_W-1:0] rdIdxA,
  input  logic [IDX_W-1:0] rdIdxB,
  output logic [CNT_W-1:0] rdCntA,
  output logic [CNT_W-1:0] rdCntB
);

  logic [CNT_W-1:0] cnt [REGS];

  for (genvar r = 0; r < REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[r] <= '0;
      end else if (load && loadIdx == IDX_W'(r)) begin
        cnt[r] <= loadVal;
      end else if (cnt[r] != '0) begin
        cnt[r] <= cnt[r] - 1'b1;
      end
    end
  end

  assign rdCntA = cnt[rdIdxA];
  assign rdCntB = cnt[rdIdxB];

endmodule

// File: rtl/ilkCtrl.sv
module ilkCtrl
  import ilkPkg::*;
#(
  parameter int IDX_W        = 5,
  parameter int CNT_W        = 2,
  parameter int FP_ALU_LAT   = 3,
  parameter int FP_LOAD_LAT  = 1,
  parameter int INT_LOAD_LAT = 1,
  parameter int STORE_CREDIT = 1
) (
  input  logic             instValid,
  input  logic [2:0]       instClass,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic [CNT_W-1:0] cntAInt,
  input  logic [CNT_W-1:0] cntBInt,
  input  logic [CNT_W-1:0] cntAFp,
  input  logic [CNT_W-1:0] cntBFp,
  output logic             stall,
  output trackStrobe_t     strobe,
  output logic [CNT_W-1:0] loadVal
);

  instClass_e cls;
  logic rdAInt, rdBInt, rdAFp, rdBFp, wrInt, wrFp;
  logic [CNT_W-1:0] creditB;
  logic hazA, hazB, advance;

  always_comb begin
    cls     = instClass_e'(instClass);
    rdAInt  = 1'b0;
    rdBInt  = 1'b0;
    rdAFp   = 1'b0;
    rdBFp   = 1'b0;
    wrInt   = 1'b0;
    wrFp    = 1'b0;
    creditB = '0;
    loadVal = '0;
    case (cls)
      CLS_INT_ALU: begin
        rdAInt = 1'b1; rdBInt = 1'b1; wrInt = 1'b1;
      end
      CLS_INT_LOAD: begin
        rdAInt = 1'b1; wrInt = 1'b1; loadVal = CNT_W'(INT_LOAD_LAT);
      end
      CLS_INT_STORE, CLS_BRANCH: begin
        rdAInt = 1'b1; rdBInt = 1'b1;
      end
      CLS_FP_ALU: begin
        rdAFp = 1'b1; rdBFp = 1'b1; wrFp = 1'b1; loadVal = CNT_W'(FP_ALU_LAT);
      end
      CLS_FP_LOAD: begin
        rdAInt = 1'b1; wrFp = 1'b1; loadVal = CNT_W'(FP_LOAD_LAT);
      end
      CLS_FP_STORE: begin
        rdAInt = 1'b1; rdBFp = 1'b1; creditB = CNT_W'(STORE_CREDIT);
      end
      default: ;
    endcase
  end

  // source A never earns credit; only store data on source B does
  assign hazA = (rdAInt && cntAInt != '0) || (rdAFp && cntAFp != '0);
  assign hazB = (rdBInt && cntBInt != '0) || (rdBFp && cntBFp > creditB);

  assign stall   = instValid && (hazA || hazB);
  assign advance = instValid && !stall;

  assign strobe.loadInt = advance && wrInt && (dstIdx != '0);
  assign strobe.loadFp  = advance && wrFp;

endmodule

// File: rtl/decodeInterlock.sv
module decodeInterlock
  import ilkPkg::*;
#(
  parameter int INT_REGS     = 32,
  parameter int FP_REGS      = 32,
  parameter int FP_ALU_LAT   = 3,
  parameter int FP_LOAD_LAT  = 1,
  parameter int INT_LOAD_LAT = 1,
  parameter int STORE_CREDIT = 1,
  localparam int IDX_W   = $clog2(INT_REGS > FP_REGS ? INT_REGS : FP_REGS),
  localparam int LAT_A   = FP_ALU_LAT > FP_LOAD_LAT ? FP_ALU_LAT : FP_LOAD_LAT,
  localparam int MAX_LAT = LAT_A > INT_LOAD_LAT ? LAT_A : INT_LOAD_LAT,
  localparam int CNT_W   = MAX_LAT < 1 ? 1 : $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instValid,
  input  logic [2:0]       instClass,
  input  logic [IDX_W-1:0] srcAIdx,
  input  logic [IDX_W-1:0] srcBIdx,
  input  logic [IDX_W-1:0] dstIdx,
  output logic             stall
);

  trackStrobe_t     strobe;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] cntAInt, cntBInt, cntAFp, cntBFp;

  ilkCountFile #(.REGS(INT_REGS), .IDX_W(IDX_W), .CNT_W(CNT_W)) intFile_i (
    .clk(clk), .rst(rst), .load(strobe.loadInt), .loadIdx(dstIdx),
    .loadVal(loadVal), .rdIdxA(srcAIdx), .rdIdxB(srcBIdx),
    .rdCntA(cntAInt), .rdCntB(cntBInt)
  );

  ilkCountFile #(.REGS(FP_REGS), .IDX_W(IDX_W), .CNT_W(CNT_W)) fpFile_i (
    .clk(clk), .rst(rst), .load(strobe.loadFp), .loadIdx(dstIdx),
    .loadVal(loadVal), .rdIdxA(srcAIdx), .rdIdxB(srcBIdx),
    .rdCntA(cntAFp), .rdCntB(cntBFp)
  );

  ilkCtrl #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .FP_ALU_LAT(FP_ALU_LAT),
    .FP_LOAD_LAT(FP_LOAD_LAT), .INT_LOAD_LAT(INT_LOAD_LAT),
    .STORE_CREDIT(STORE_CREDIT)
  ) ctrl_i (
    .instValid(instValid), .instClass(instClass), .dstIdx(dstIdx),
    .cntAInt(cntAInt), .cntBInt(cntBInt), .cntAFp(cntAFp), .cntBFp(cntBFp),
    .stall(stall), .strobe(strobe), .loadVal(loadVal)
  );

endmodule

// File: rtl/decodeInterlockChk.sv
module decodeInterlockChk #(
  parameter int IDX_W   = 5,
  parameter int MAX_LAT = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             instValid,
  input logic [2:0]       instClass,
  input logic [IDX_W-1:0] srcAIdx,
  input logic [IDX_W-1:0] srcBIdx,
  input logic [IDX_W-1:0] dstIdx,
  input logic             stall
);

  int stallRun;

  always_ff @(posedge clk) begin
    if (rst)        stallRun <= 0;
    else if (stall) stallRun <= stallRun + 1;
    else            stallRun <= 0;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !stall);

  p_fp_chain_r2: assert property (@(posedge clk) disable iff (rst)
    (instValid && instClass == 3'd4 && srcAIdx == $past(dstIdx) && $past(!rst)
     && $past(instValid && !stall && instClass == 3'd4)) |-> stall);

  p_int_alu_free_r7: assert property (@(posedge clk) disable iff (rst)
    (instValid && instClass == 3'd0 && srcAIdx == srcBIdx
     && srcAIdx == $past(dstIdx) && $past(!rst)
     && $past(instValid && !stall && instClass == 3'd0)) |-> !stall);

  p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
    (instValid && (instClass == 3'd0 || instClass == 3'd2 || instClass == 3'd3)
     && srcAIdx == '0 && srcBIdx == '0) |-> !stall);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !instValid |-> !stall);

  p_stall_bounded_r12: assert property (@(posedge clk) disable iff (rst)
    stall |-> stallRun < MAX_LAT);

endmodule

bind decodeInterlock decodeInterlockChk #(.IDX_W(IDX_W), .MAX_LAT(MAX_LAT)) chk_i (
  .clk(clk), .rst(rst), .instValid(instValid), .instClass(instClass),
  .srcAIdx(srcAIdx), .srcBIdx(srcBIdx), .dstIdx(dstIdx), .stall(stall)
);

// File: tb/decodeInterlock_tb_top.sv
module decodeInterlock_tb_top;

  localparam logic [2:0] IALU = 3'd0, ILD = 3'd1, IST = 3'd2, BR = 3'd3;
  localparam logic [2:0] FALU = 3'd4, FLD = 3'd5, FST = 3'd6;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic       rst = 1'b1;
  logic       instValid = 1'b0;
  logic [2:0] instClass = 3'd7;
  logic [4:0] srcAIdx = '0, srcBIdx = '0, dstIdx = '0;
  logic       stall;

  int checks = 0;
  int errors = 0;
  int run = 0;

  typedef struct {
    int    stalls;
    string req;
  } exp_t;
  exp_t expQ[$];

  decodeInterlock dut_i (
    .clk(clk), .rst(rst), .instValid(instValid), .instClass(instClass),
    .srcAIdx(srcAIdx), .srcBIdx(srcBIdx), .dstIdx(dstIdx), .stall(stall)
  );

  // driver: push expected stall count, hold the instruction until it advances
  task automatic drive(input logic [2:0] c, input logic [4:0] a, input logic [4:0] b,
                       input logic [4:0] d, input int exp, input string req);
    exp_t e;
    e.stalls = exp;
    e.req = req;
    instValid = 1'b1; instClass = c; srcAIdx = a; srcBIdx = b; dstIdx = d;
    expQ.push_back(e);
    do @(negedge clk); while (stall);
    @(posedge clk); #1;
    instValid = 1'b0;
  endtask

  task automatic idle(input int n, input bit chk, input string req);
    instValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (chk) begin
        checks++;
        if (stall !== 1'b0) begin
          errors++;
          $display("FAIL %s idle stall=%0b expected=0", req, stall);
        end
      end
      @(posedge clk); #1;
    end
  endtask

  // monitor: count stall cycles per instruction and compare on advance
  always @(negedge clk) begin
    if (!rst && instValid) begin
      if (stall === 1'b1) begin
        run++;
      end else begin
        exp_t e;
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL unexpected advance stalls=%0d expected=none", run);
        end else begin
          e = expQ.pop_front();
          if (run != e.stalls || stall !== 1'b0) begin
            errors++;
            $display("FAIL %s stalls=%0d expected=%0d", e.req, run, e.stalls);
          end
        end
        run = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired checks=%0d expected=finish", checks);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle(1, 1'b1, "R1");

    // R1: pending result wiped by a mid-run reset
    drive(FALU, 1, 2, 5, 0, "R1");
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1 rst = 1'b0;
    drive(FALU, 5, 5, 6, 0, "R1");
    idle(4, 1'b0, "");

    // R2 adjacent (also the R12 three-cycle bound), then a one-cycle gap on source B
    drive(FALU, 1, 2, 3, 0, "R2");
    drive(FALU, 3, 4, 7, 3, "R2,R12");
    idle(4, 1'b0, "");
    drive(FALU, 1, 2, 8, 0, "R2");
    drive(IALU, 4, 5, 6, 0, "R7");
    drive(FALU, 9, 8, 10, 2, "R2");
    idle(4, 1'b0, "");

    // R3: FP arithmetic into store data, gaps 0, 2 and 1
    drive(FALU, 1, 2, 12, 0, "R3");
    drive(FST, 1, 12, 0, 2, "R3");
    idle(4, 1'b0, "");
    drive(FALU, 1, 2, 13, 0, "R3");
    idle(2, 1'b0, "");
    drive(FST, 1, 13, 0, 0, "R3");
    drive(FALU, 1, 2, 14, 0, "R3");
    idle(1, 1'b0, "");
    drive(FST, 1, 14, 0, 1, "R3");
    idle(4, 1'b0, "");

    // R4 / R5: FP load
    drive(FLD, 2, 0, 15, 0, "R4");
    drive(FALU, 15, 15, 16, 1, "R4");
    idle(4, 1'b0, "");
    drive(FLD, 2, 0, 17, 0, "R5");
    drive(FST, 3, 17, 0, 0, "R5");
    idle(4, 1'b0, "");

    // R6: integer load into ALU, branch, store data
    drive(ILD, 1, 0, 5, 0, "R6");
    drive(IALU, 5, 6, 7, 1, "R6");
    idle(4, 1'b0, "");
    drive(ILD, 1, 0, 8, 0, "R6");
    drive(BR, 9, 8, 0, 1, "R6");
    idle(4, 1'b0, "");
    drive(ILD, 1, 0, 9, 0, "R6");
    drive(IST, 10, 9, 0, 1, "R6");
    idle(4, 1'b0, "");

    // R10: base address operand gets no credit
    drive(ILD, 1, 0, 11, 0, "R10");
    drive(FLD, 11, 0, 18, 1, "R10");
    idle(4, 1'b0, "");
    drive(ILD, 1, 0, 12, 0, "R10");
    drive(FST, 12, 19, 0, 1, "R10");
    idle(4, 1'b0, "");

    // R7: integer ALU results are free
    drive(IALU, 1, 2, 13, 0, "R7");
    drive(BR, 13, 13, 0, 0, "R7");
    drive(IALU, 1, 2, 14, 0, "R7");
    drive(ILD, 14, 0, 15, 0, "R7");
    idle(4, 1'b0, "");

    // R8: register zero
    drive(ILD, 1, 0, 0, 0, "R8");
    drive(IALU, 0, 0, 16, 0, "R8");
    drive(ILD, 1, 0, 0, 0, "R8");
    drive(IST, 0, 0, 0, 0, "R8");
    idle(4, 1'b0, "");

    // R9: invalid slot with a hazardous pattern, then source B hazard
    drive(FALU, 1, 2, 20, 0, "R9");
    instClass = FALU; srcAIdx = 20; srcBIdx = 20;
    idle(1, 1'b1, "R9");
    drive(FALU, 1, 20, 21, 2, "R9");
    idle(4, 1'b0, "");

    // R11: stalled instruction rewriting its own source
    drive(FALU, 1, 2, 22, 0, "R11");
    drive(FALU, 22, 22, 22, 3, "R11");
    drive(FALU, 22, 1, 23, 3, "R11");
    idle(4, 1'b0, "");

    // R13: files are independent
    drive(FALU, 1, 2, 24, 0, "R13");
    drive(IALU, 24, 24, 25, 0, "R13");
    idle(4, 1'b0, "");
    drive(ILD, 1, 0, 26, 0, "R13");
    drive(FALU, 26, 26, 27, 0, "R13");
    idle(2, 1'b0, "");

    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL leftover items=%0d expected=0", expQ.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule